// File: doc/BRIEF.md
# SPI Slave Memory Access Port

This block lets an external host reach a 16-bit-addressed, byte-wide memory bus over a four-wire SPI link. The host lowers the active-low select and clocks in a command byte, a 16-bit address and then any number of data bytes. The pointer steps by one after every byte. Depending on the command, bytes are read from memory and returned on the serial output, written into memory, or discarded. Bits travel MSB first. The host drives input bits that are sampled on rising serial-clock edges. The port changes its output bits on falling edges, and the output is enabled only while the port is selected.

All four serial pins are sampled in the system clock domain through a short synchronizer, and edges are recovered there. Memory accesses use a request/acknowledge handshake, one request per byte. A read fetch is issued as soon as the last address bit (or the last bit of a data byte) arrives, so the next byte is ready before the host's next falling edge. The most recent command byte and the most recent complete address are held in registers that the CPU can read. When select rises, the port sends the CPU a one-cycle interrupt pulse for every command except the two quiet codes.

Top module: `spi_mem_port`

## Requirements
- R1: While select is high, the output enable `spi_miso_oe` is 0, serial clock and data activity cause no memory access, no interrupt and no register change, and any partially received frame is discarded.
- R2: After select falls, bits are sampled MSB first on rising serial-clock edges: 8 command bits, then 16 address bits, then data bytes of 8 bits each.
- R3: A command with bits [7:6] = 11 is a read: the bytes at address, address+1, ... are returned MSB first on `spi_miso` during the data bytes, each bit changing on a falling serial-clock edge.
- R4: A command with bits [7:6] = 10 is a write: each complete data byte is written to address, address+1, ..., and a trailing partial byte is not written.
- R5: When select rises after a complete command byte, `cpu_irq` pulses high for exactly one system clock, except for commands 0xC0 and 0x80. There is no pulse if the command byte was incomplete.
- R6: A command with bits [7:6] = 00 or 01 makes no memory access, and the data bytes that follow it are discarded.
- R7: `last_cmd` takes each command byte when its 8th bit arrives. `last_addr` changes only when all 16 address bits of a frame have arrived, so a shorter frame leaves it unchanged. Both registers reset to 0.
- R8: The byte pointer wraps from 0xFFFF to 0x0000 within a transfer.
- R9: `mem_req` stays high with stable `mem_we`, `mem_addr` and `mem_wdata` until `mem_ack`, and read data is taken from `mem_rdata` in the acknowledge cycle.
- R10: A frame that carries only a command byte is legal. It updates `last_cmd` and raises the interrupt according to R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Active-low select from the host |
| spi_sck | input | 1 | Serial clock from the host, idle low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for the `spi_miso` pad driver |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | DATA_W | Write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | DATA_W | Read data, valid with `mem_ack` |
| cpu_irq | output | 1 | One-cycle interrupt pulse to the CPU |
| last_cmd | output | 8 | Most recent command byte |
| last_addr | output | ADDR_W | Most recent complete address |

## Verification
The bench builds the port with its default values: a two-stage synchronizer, a 16-bit address and 8-bit data. It drives the serial clock at a half period of six system clocks. Every one of the 256 command codes is sent once with its own address and data byte. This covers all four command classes, the two quiet codes and the class boundaries, and each result is checked against arithmetic in the bench. With the full 16-bit address, the pointer can be steered to 0xFFFF to exercise the wrap. Directed frames then cover bursts, truncated frames and activity while the port is deselected.

// File: rtl/spimp_pkg.sv
package spimp_pkg;

  localparam int CMD_BITS = 8;

  // command classes, decoded from the top two command bits
  typedef enum logic [1:0] {
    K_CTRL  = 2'd0,
    K_WRITE = 2'd1,
    K_READ  = 2'd2
  } kind_e;

  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

  localparam logic [CMD_BITS-1:0] RD_QUIET = 8'hC0;
  localparam logic [CMD_BITS-1:0] WR_QUIET = 8'h80;

  function automatic kind_e cmd_kind(input logic [CMD_BITS-1:0] c);
    case (c[CMD_BITS-1 -: 2])
      2'b11:   return K_READ;
      2'b10:   return K_WRITE;
      default: return K_CTRL;
    endcase
  endfunction

  function automatic logic cmd_raises_irq(input logic [CMD_BITS-1:0] c);
    return (c != RD_QUIET) && (c != WR_QUIET);
  endfunction

endpackage

// File: rtl/spimp_sync.sv
// Brings the serial pins into the system clock domain and recovers edges.
module spimp_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  output logic sel,
  output logic desel_ev,
  output logic sck_rise,
  output logic sck_fall,
  output logic mosi_s
);
  localparam int LANES = 3;
  localparam int CHAIN_W = SYNC_STAGES * LANES;
  localparam logic [LANES-1:0] IDLE = 3'b001;  // {mosi, sck, cs_n}

  logic [CHAIN_W-1:0] chain;
  logic [LANES-1:0]   tap;
  logic               sck_q, cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {SYNC_STAGES{IDLE}};
    else        chain <= {chain[CHAIN_W-LANES-1:0], mosi, sck, cs_n};
  end

  assign tap = chain[CHAIN_W-1 -: LANES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= tap[1];
      cs_q  <= tap[0];
    end
  end

  assign sel      = !tap[0];
  assign desel_ev = tap[0] && !cs_q;
  assign sck_rise = sel && tap[1] && !sck_q;
  assign sck_fall = sel && !tap[1] && sck_q;
  assign mosi_s   = tap[2];
endmodule

// File: rtl/spimp_frame.sv
// Splits the serial stream into command, address and data fields.
module spimp_frame import spimp_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sel,
  input  logic                      sck_rise,
  input  logic                      mosi_s,
  output logic [CMD_BITS-1:0]       cmd_q,
  output logic                      cmd_valid,
  output logic [ADDR_W-1:0]         addr_q,
  output logic [DATA_W-1:0]         byte_q,
  output logic                      ev_addr,
  output logic                      ev_byte,
  output logic                      in_data,
  output logic [$clog2(DATA_W)-1:0] data_pos
);
  localparam int CNT_W  = $clog2(ADDR_W);
  localparam int DPOS_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_BITS - 1);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  phase_e            phase;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] shreg, nxt;

  assign nxt = {shreg[ADDR_W-2:0], mosi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_CMD;
      cnt       <= '0;
      shreg     <= '0;
      cmd_q     <= '0;
      cmd_valid <= 1'b0;
      addr_q    <= '0;
      byte_q    <= '0;
      ev_addr   <= 1'b0;
      ev_byte   <= 1'b0;
    end else begin
      ev_addr <= 1'b0;
      ev_byte <= 1'b0;
      if (!sel) begin
        phase     <= PH_CMD;
        cnt       <= '0;
        cmd_valid <= 1'b0;
      end else if (sck_rise) begin
        shreg <= nxt;
        case (phase)
          PH_CMD: begin
            if (cnt == CMD_LAST) begin
              cmd_q     <= nxt[CMD_BITS-1:0];
              cmd_valid <= 1'b1;
              phase     <= PH_ADDR;
              cnt       <= '0;
            end else cnt <= cnt + 1'b1;
          end
          PH_ADDR: begin
            if (cnt == ADDR_LAST) begin
              addr_q  <= nxt;
              ev_addr <= 1'b1;
              phase   <= PH_DATA;
              cnt     <= '0;
            end else cnt <= cnt + 1'b1;
          end
          default: begin
            if (cnt == DATA_LAST) begin
              byte_q  <= nxt[DATA_W-1:0];
              ev_byte <= 1'b1;
              cnt     <= '0;
            end else cnt <= cnt + 1'b1;
          end
        endcase
      end
    end
  end

  assign in_data  = (phase == PH_DATA);
  assign data_pos = cnt[DPOS_W-1:0];
endmodule

// File: rtl/spimp_bus.sv
// Issues one memory request per byte and keeps the running byte pointer.
module spimp_bus import spimp_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  kind_e             kind,
  input  logic              ev_addr,
  input  logic              ev_byte,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] byte_in,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] rd_buf,
  output logic              ev_issue
);
  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
    return a + 1'b1;  // wraps at the top of the address space
  endfunction

  logic [ADDR_W-1:0] ptr, tgt;
  logic              want_rd, want_wr, slot_free;

  always_comb begin
    want_rd   = (kind == K_READ) && (ev_addr || ev_byte);
    want_wr   = (kind == K_WRITE) && ev_byte;
    tgt       = ev_addr ? addr_in : ptr;
    slot_free = !mem_req || mem_ack;
  end

  assign ev_issue = (want_rd || want_wr) && slot_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr       <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      rd_buf    <= '0;
    end else begin
      if (mem_req && mem_ack) begin
        mem_req <= 1'b0;
        if (!mem_we) rd_buf <= mem_rdata;
      end
      if (ev_addr) ptr <= addr_in;
      if (ev_issue) begin
        mem_req   <= 1'b1;
        mem_we    <= want_wr;
        mem_addr  <= tgt;
        mem_wdata <= byte_in;
        ptr       <= step_addr(tgt);
      end
    end
  end
endmodule

// File: rtl/spimp_tx.sv
// Output shifter: loads a fetched byte at each byte boundary, shifts on falls.
module spimp_tx #(
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sel,
  input  logic                      sck_fall,
  input  logic                      in_data,
  input  logic                      is_read,
  input  logic [$clog2(DATA_W)-1:0] data_pos,
  input  logic [DATA_W-1:0]         rd_buf,
  output logic                      miso,
  output logic                      miso_oe
);
  logic [DATA_W-1:0] txsh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      txsh <= '0;
    else if (!sel)   txsh <= '0;
    else if (sck_fall && in_data && is_read) begin
      if (data_pos == '0) txsh <= rd_buf;
      else                txsh <= {txsh[DATA_W-2:0], 1'b0};
    end
  end

  assign miso    = txsh[DATA_W-1];
  assign miso_oe = sel;
endmodule

// File: rtl/spi_mem_port.sv
module spi_mem_port import spimp_pkg::*; #(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                spi_cs_n,
  input  logic                spi_sck,
  input  logic                spi_mosi,
  output logic                spi_miso,
  output logic                spi_miso_oe,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic                mem_ack,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                cpu_irq,
  output logic [CMD_BITS-1:0] last_cmd,
  output logic [ADDR_W-1:0]   last_addr
);
  localparam int DPOS_W = $clog2(DATA_W);

  // named internal events, also watched by the bound checker
  logic                sel_w, desel_w, rise_w, fall_w, mosi_w;
  logic                ev_addr_w, ev_byte_w, ev_issue_w;
  logic                cmd_valid_w, in_data_w;
  logic [DPOS_W-1:0]   dpos_w;
  logic [CMD_BITS-1:0] cmd_w;
  logic [ADDR_W-1:0]   addr_w;
  logic [DATA_W-1:0]   byte_w, rd_buf_w;
  kind_e               kind_w;

  spimp_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .cs_n(spi_cs_n), .sck(spi_sck), .mosi(spi_mosi),
    .sel(sel_w), .desel_ev(desel_w),
    .sck_rise(rise_w), .sck_fall(fall_w), .mosi_s(mosi_w)
  );

  spimp_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .sel(sel_w), .sck_rise(rise_w), .mosi_s(mosi_w),
    .cmd_q(cmd_w), .cmd_valid(cmd_valid_w),
    .addr_q(addr_w), .byte_q(byte_w),
    .ev_addr(ev_addr_w), .ev_byte(ev_byte_w),
    .in_data(in_data_w), .data_pos(dpos_w)
  );

  assign kind_w = cmd_kind(cmd_w);

  spimp_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk(clk), .rst_n(rst_n),
    .kind(kind_w), .ev_addr(ev_addr_w), .ev_byte(ev_byte_w),
    .addr_in(addr_w), .byte_in(byte_w),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .rd_buf(rd_buf_w), .ev_issue(ev_issue_w)
  );

  spimp_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .sel(sel_w), .sck_fall(fall_w), .in_data(in_data_w),
    .is_read(kind_w == K_READ), .data_pos(dpos_w), .rd_buf(rd_buf_w),
    .miso(spi_miso), .miso_oe(spi_miso_oe)
  );

  // interrupt: one pulse per deselect that closes a complete command byte
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cpu_irq <= 1'b0;
    else        cpu_irq <= desel_w && cmd_valid_w && cmd_raises_irq(cmd_w);
  end

  assign last_cmd  = cmd_w;
  assign last_addr = addr_w;
endmodule

// File: rtl/spimp_checker.sv
module spimp_checker import spimp_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_w,
  input logic              desel_w,
  input logic              ev_addr_w,
  input logic              ev_issue_w,
  input kind_e             kind_w,
  input logic              cpu_irq,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [ADDR_W-1:0] last_addr
);
  // R1: no memory access is started once the port has been deselected
  a_r1_no_access_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_w && $past(!sel_w)) |-> !ev_issue_w);

  // R5: the interrupt is a single-cycle pulse
  a_r5_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |=> !cpu_irq);

  // R5: the interrupt follows a deselect event
  a_r5_irq_after_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> $past(desel_w));

  // R6: control commands never reach memory
  a_r6_ctrl_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    ev_issue_w |-> (kind_w != K_CTRL));

  // R4: a write request comes only from a write command
  a_r4_write_from_write_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_issue_w && (kind_w != K_WRITE)) |=> !mem_we);

  // R9: request held steady until acknowledged
  a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));

  // R7: the address register moves only with a completed address field
  a_r7_addr_changes_on_field: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(last_addr) |-> ev_addr_w);
endmodule

bind spi_mem_port spimp_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_w(sel_w), .desel_w(desel_w),
  .ev_addr_w(ev_addr_w), .ev_issue_w(ev_issue_w), .kind_w(kind_w),
  .cpu_irq(cpu_irq), .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .last_addr(last_addr)
);

// File: tb/tb_spi_mem_port.sv
module tb_spi_mem_port;
  localparam int HALF     = 6;       // serial half period in system clocks
  localparam int WD_LIMIT = 190000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic        spi_miso, spi_miso_oe;
  logic        mem_req, mem_we, mem_ack;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        cpu_irq;
  logic [7:0]  last_cmd;
  logic [15:0] last_addr;

  spi_mem_port dut (
    .clk(clk), .rst_n(rst_n),
    .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
    .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .cpu_irq(cpu_irq), .last_cmd(last_cmd), .last_addr(last_addr)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  int acc_cnt = 0, irq_cnt = 0, irq_wide = 0;
  logic [15:0] acc_log [16];
  logic [7:0]  ram [256];
  logic [7:0]  exp_mem [256];
  logic        irq_prev = 1'b0;

  function automatic logic [7:0] seed(input int a);
    return 8'((a * 37 + 5) & 255);
  endfunction

  // memory model: acknowledges one cycle after a request, decodes 8 address bits
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= 8'h00;
      for (int i = 0; i < 256; i++) ram[i] <= seed(i);
    end else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
      else        mem_rdata <= ram[mem_addr[7:0]];
      acc_log[acc_cnt & 15] <= mem_addr;
      acc_cnt <= acc_cnt + 1;
    end else begin
      mem_ack <= 1'b0;
    end
  end

  always @(posedge clk) begin
    if (cpu_irq) irq_cnt <= irq_cnt + 1;
    if (cpu_irq && irq_prev) irq_wide <= irq_wide + 1;
    irq_prev <= cpu_irq;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT) begin
      n_chk = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk = n_chk + 1;
    if (act != exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel_on();
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic sel_off();
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(12);
  endtask

  // shifts n bits of v out MSB first, collecting the port's output bits
  task automatic xbits(input logic [31:0] v, input int n, output logic [31:0] rx);
    rx = '0;
    for (int i = n - 1; i >= 0; i--) begin
      mosi = v[i];
      wait_clk(HALF);
      rx = {rx[30:0], spi_miso};
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
  endtask

  logic [31:0] rx;
  logic [7:0]  cb, db;
  logic [15:0] ab;
  int a0, i0, base;

  initial begin
    for (int i = 0; i < 256; i++) exp_mem[i] = seed(i);
    wait_clk(5);
    chk("R7", "last_cmd at reset", int'(last_cmd), 0);
    chk("R7", "last_addr at reset", int'(last_addr), 0);
    chk("R1", "oe at reset", int'(spi_miso_oe), 0);
    chk("R5", "irq at reset", int'(cpu_irq), 0);
    chk("R9", "req at reset", int'(mem_req), 0);
    rst_n = 1'b1;
    wait_clk(5);

    // sweep over every command code
    for (int c = 0; c < 256; c++) begin
      cb = 8'(c);
      ab = {cb, ~cb};
      db = cb ^ 8'h5A;
      a0 = acc_cnt;
      i0 = irq_cnt;
      sel_on();
      xbits({24'h0, cb}, 8, rx);
      xbits({16'h0, ab}, 16, rx);
      xbits({24'h0, db}, 8, rx);
      sel_off();
      chk("R7", "last_cmd after sweep frame", int'(last_cmd), c);
      chk("R2", "last_addr after sweep frame", int'(last_addr), int'(ab));
      chk("R5", "irq count for command", irq_cnt - i0,
          (c != 8'hC0 && c != 8'h80) ? 1 : 0);
      if (cb[7:6] == 2'b11) begin
        chk("R3", "read byte", int'(rx[7:0]), int'(exp_mem[ab[7:0]]));
        chk("R3", "read accesses", acc_cnt - a0, 2);
      end else if (cb[7:6] == 2'b10) begin
        exp_mem[ab[7:0]] = db;
        chk("R4", "written byte", int'(ram[ab[7:0]]), int'(db));
        chk("R4", "write accesses", acc_cnt - a0, 1);
      end else begin
        chk("R6", "control accesses", acc_cnt - a0, 0);
        chk("R6", "memory untouched", int'(ram[ab[7:0]]), int'(exp_mem[ab[7:0]]));
      end
    end

    // burst write with a trailing partial byte
    a0 = acc_cnt; i0 = irq_cnt;
    sel_on();
    chk("R1", "oe while selected", int'(spi_miso_oe), 1);
    xbits(32'h80, 8, rx);
    xbits(32'h0010, 16, rx);
    for (int k = 0; k < 4; k++) begin
      xbits(32'(8'h11 * (k + 1)), 8, rx);
      exp_mem[16 + k] = 8'(8'h11 * (k + 1));
    end
    xbits(32'h5, 3, rx);
    sel_off();
    chk("R1", "oe after deselect", int'(spi_miso_oe), 0);
    chk("R4", "burst write accesses, partial byte dropped", acc_cnt - a0, 4);
    chk("R5", "quiet write irq", irq_cnt - i0, 0);
    for (int k = 0; k < 5; k++)
      chk("R4", "burst write contents", int'(ram[16 + k]), int'(exp_mem[16 + k]));

    // burst read of the same bytes
    a0 = acc_cnt; i0 = irq_cnt;
    sel_on();
    xbits(32'hC0, 8, rx);
    xbits(32'h0010, 16, rx);
    for (int k = 0; k < 4; k++) begin
      xbits(32'h0, 8, rx);
      chk("R3", "burst read byte", int'(rx[7:0]), int'(exp_mem[16 + k]));
    end
    sel_off();
    chk("R3", "burst read accesses", acc_cnt - a0, 5);
    chk("R5", "quiet read irq", irq_cnt - i0, 0);

    // command-only frame
    a0 = acc_cnt; i0 = irq_cnt;
    sel_on();
    xbits(32'h3C, 8, rx);
    sel_off();
    chk("R10", "command-only last_cmd", int'(last_cmd), 8'h3C);
    chk("R10", "command-only irq", irq_cnt - i0, 1);
    chk("R7", "command-only keeps last_addr", int'(last_addr), 16'h0010);
    chk("R6", "command-only accesses", acc_cnt - a0, 0);

    // command with a truncated address field
    i0 = irq_cnt;
    sel_on();
    xbits(32'h41, 8, rx);
    xbits(32'hAB, 8, rx);
    sel_off();
    chk("R7", "truncated address keeps last_addr", int'(last_addr), 16'h0010);
    chk("R7", "truncated address last_cmd", int'(last_cmd), 8'h41);
    chk("R5", "truncated address irq", irq_cnt - i0, 1);

    // control command followed by data bytes
    a0 = acc_cnt; i0 = irq_cnt;
    sel_on();
    xbits(32'h7E, 8, rx);
    xbits(32'h1234, 16, rx);
    xbits(32'hFF, 8, rx);
    xbits(32'h00, 8, rx);
    sel_off();
    chk("R6", "control data ignored, accesses", acc_cnt - a0, 0);
    chk("R6", "control data ignored, memory", int'(ram[8'h34]), int'(exp_mem[8'h34]));
    chk("R7", "control last_addr", int'(last_addr), 16'h1234);
    chk("R5", "control irq", irq_cnt - i0, 1);

    // partial command byte
    i0 = irq_cnt;
    sel_on();
    xbits(32'h1F, 5, rx);
    sel_off();
    chk("R5", "partial command no irq", irq_cnt - i0, 0);
    chk("R7", "partial command keeps last_cmd", int'(last_cmd), 8'h7E);

    // activity while deselected
    a0 = acc_cnt; i0 = irq_cnt;
    for (int k = 0; k < 40; k++) begin
      mosi = k[1];
      sck = k[0];
      wait_clk(3);
    end
    sck = 1'b0;
    wait_clk(12);
    chk("R1", "deselected accesses", acc_cnt - a0, 0);
    chk("R1", "deselected irq", irq_cnt - i0, 0);
    chk("R1", "deselected last_cmd", int'(last_cmd), 8'h7E);
    chk("R1", "deselected oe", int'(spi_miso_oe), 0);

    // pointer wrap on write and read
    a0 = acc_cnt; i0 = irq_cnt;
    sel_on();
    xbits(32'h81, 8, rx);
    xbits(32'hFFFF, 16, rx);
    xbits(32'h5C, 8, rx);
    xbits(32'hC5, 8, rx);
    sel_off();
    exp_mem[8'hFF] = 8'h5C;
    exp_mem[8'h00] = 8'hC5;
    chk("R8", "first write address", int'(acc_log[a0 & 15]), 16'hFFFF);
    chk("R8", "wrapped write address", int'(acc_log[(a0 + 1) & 15]), 16'h0000);
    chk("R8", "wrapped write data", int'(ram[8'h00]), 8'hC5);
    chk("R5", "write with irq", irq_cnt - i0, 1);
    base = acc_cnt;
    sel_on();
    xbits(32'hC1, 8, rx);
    xbits(32'hFFFF, 16, rx);
    xbits(32'h0, 8, rx);
    chk("R8", "read at top address", int'(rx[7:0]), int'(exp_mem[8'hFF]));
    xbits(32'h0, 8, rx);
    chk("R8", "read after wrap", int'(rx[7:0]), int'(exp_mem[8'h00]));
    sel_off();
    chk("R8", "wrapped read address", int'(acc_log[(base + 1) & 15]), 16'h0000);

    chk("R5", "irq pulses wider than one cycle", irq_wide, 0);
    chk("R9", "request idle at end", int'(mem_req), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule